// File: doc/BRIEF.md
# Register list transfer sequencer

This block turns one command, a mask of low registers plus one optional extra slot, into a run of single-word memory transfers. It then updates the address register. It reads and writes the register file through its own ports. It also drives a word memory port that answers in the same cycle. When the run is over it pulses `done` for one cycle. At that point it also reports the cost of the operation as counts of non-sequential (N), sequential (S) and internal (I) cycles. Decode and the memory itself are outside the block.

There are two modes, selected by `cmd_mode`:

- **Stack mode** (`cmd_mode` = 0) uses the stack pointer at register index 13.
  - A store is a push. It lowers the stack pointer first and fills upward.
  - A load is a pop. It reads upward from the stack pointer.
  - The extra slot adds the link register (index 14) to a push, or the program counter (index 15) to a pop.
- **Base mode** (`cmd_mode` = 1) uses any low register, named by `cmd_base`, as an incrementing base with writeback. The extra slot has no meaning in this mode.

Commands arrive on a valid/ready handshake. `cmd_ready` is high only while the sequencer is idle. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. While `cmd_ready` is low, the source holds the command and the block ignores every `cmd_*` input. `done` and the cost outputs are plain status pins.

Top module: `regseq_top`

## Requirements
- R1: Listed registers are transferred in ascending index order to ascending word addresses. Each transfer is 4 above the one before, and the extra slot comes after all listed registers.
- R2: A push with T transfers starts at SP-4T. SP ends at SP-4T. With the extra bit set, register 14 is stored in the highest word.
- R3: A pop reads upward from SP and leaves SP increased by 4T. With the extra bit set, the last word is written to register 15 plus 4.
- R4: In base mode, a store stores the original base value if the base register is in the list. At the end the base is written with base+4n, and this wins over a value loaded into it. The extra bit is ignored.
- R5: On a load, no register outside the list is written, apart from the final SP or base writeback. A store writes no register during its transfers.
- R6: The reported costs, with n the number of listed registers and e the effective extra bit, are:
  - Store: N=2, S=n+e-1, I=0.
  - Load: N=1+e, S=n+2e, I=1.
  - Empty list: all three costs are 0.
- R7: An empty run (n+e=0) makes no memory access and writes no register. It asserts `done` in the first cycle after acceptance.
- R8: The block makes at most one memory transfer per cycle. A run of T>0 transfers uses T consecutive cycles. `done` is high in cycle T+2 after acceptance and lasts exactly one cycle.
- R9: `cmd_ready` is high exactly while idle. A command presented while busy is neither taken nor able to disturb the running one, and it is taken once the block is idle again.
- R10: During reset `cmd_ready` is high and `mem_en`, `rf_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_mode | input | 1 | 0 stack, 1 base with writeback |
| cmd_load | input | 1 | 1 load from memory, 0 store to memory |
| cmd_list | input | LIST_W | Low register mask, bit i selects register i |
| cmd_extra | input | 1 | Stack mode: add register 14 (store) or 15 (load) |
| cmd_base | input | $clog2(LIST_W) | Base register index in base mode |
| rf_raddr | output | REG_AW | Register file read index |
| rf_rdata | input | DATA_W | Register file read data, same cycle |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | REG_AW | Register file write index |
| rf_wdata | output | DATA_W | Register file write data |
| mem_en | output | 1 | Memory transfer this cycle |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | DATA_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, same cycle |
| done | output | 1 | One-cycle completion pulse |
| cost_n | output | COST_W | N cycles of the last run |
| cost_s | output | COST_W | S cycles of the last run |
| cost_i | output | COST_W | I cycles of the last run |

## Verification
The bench builds the block with its default eight-wide list and 32-bit data. That puts the full mask 0xFF plus the extra slot within reach, which gives the longest run (nine transfers) and the largest S cost. It also lets the base register fall inside the list, so the original-value store and the writeback-over-load case both occur. Lists with holes, such as 0xD3 and 0xD5, show that skipped indices neither take an address nor get written. A command held valid across a busy run checks the back-pressure rule.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_XFER = 2'd2,
    ST_WB   = 2'd3
  } seq_state_t;

  localparam logic MODE_STACK = 1'b0;
  localparam logic MODE_BASE  = 1'b1;
endpackage

// File: rtl/regseq_pick.sv
// Isolates the lowest set bit of a mask and encodes its index.
module regseq_pick #(
  parameter int W = 8
) (
  input  logic [W-1:0]         mask,
  output logic [W-1:0]         onehot,
  output logic [$clog2(W)-1:0] idx,
  output logic                 any,
  output logic                 more
);
  localparam int IW = $clog2(W);

  logic [IW-1:0] terms [W];

  assign onehot = mask & (~mask + W'(1));
  assign any    = |mask;
  assign more   = |(mask & ~onehot);

  for (genvar i = 0; i < W; i++) begin : g_term
    assign terms[i] = onehot[i] ? IW'(i) : '0;
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) idx = idx | terms[i];
  end
endmodule

// File: rtl/regseq_plan.sv
// Per-run arithmetic: transfer count, first address, writeback value, costs.
module regseq_plan #(
  parameter int LIST_W = 8,
  parameter int DATA_W = 32,
  parameter int COST_W = 5
) (
  input  logic [LIST_W-1:0] list,
  input  logic              extra,
  input  logic              is_load,
  input  logic              is_push,
  input  logic [DATA_W-1:0] base,
  output logic              empty,
  output logic [DATA_W-1:0] start_addr,
  output logic [DATA_W-1:0] wb_value,
  output logic [COST_W-1:0] cost_n,
  output logic [COST_W-1:0] cost_s,
  output logic [COST_W-1:0] cost_i
);
  localparam int CW = $clog2(LIST_W + 2);

  logic [CW-1:0]     n_low;
  logic [CW-1:0]     total;
  logic [DATA_W-1:0] span;

  always_comb begin
    n_low = '0;
    for (int i = 0; i < LIST_W; i++) n_low = n_low + CW'(list[i]);
  end

  assign total = n_low + CW'(extra);
  assign empty = (total == '0);
  assign span  = DATA_W'(total) << 2;

  assign start_addr = is_push ? (base - span) : base;
  assign wb_value   = is_push ? (base - span) : (base + span);

  always_comb begin
    cost_n = '0;
    cost_s = '0;
    cost_i = '0;
    if (!empty) begin
      if (!is_load) begin
        cost_n = COST_W'(2);
        cost_s = COST_W'(total) - COST_W'(1);
      end else begin
        cost_n = COST_W'(1) + COST_W'(extra);
        cost_s = COST_W'(n_low) + (COST_W'(extra) << 1);
        cost_i = COST_W'(1);
      end
    end
  end
endmodule

// File: rtl/regseq_top.sv
module regseq_top #(
  parameter int LIST_W = 8,
  parameter int DATA_W = 32,
  parameter int REG_AW = 4,
  parameter int SP_IDX = 13,
  parameter int LR_IDX = 14,
  parameter int PC_IDX = 15,
  parameter int COST_W = $clog2(LIST_W + 3) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic                      cmd_mode,
  input  logic                      cmd_load,
  input  logic [LIST_W-1:0]         cmd_list,
  input  logic                      cmd_extra,
  input  logic [$clog2(LIST_W)-1:0] cmd_base,
  output logic [REG_AW-1:0]         rf_raddr,
  input  logic [DATA_W-1:0]         rf_rdata,
  output logic                      rf_we,
  output logic [REG_AW-1:0]         rf_waddr,
  output logic [DATA_W-1:0]         rf_wdata,
  output logic                      mem_en,
  output logic                      mem_we,
  output logic [DATA_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic [DATA_W-1:0]         mem_rdata,
  output logic                      done,
  output logic [COST_W-1:0]         cost_n,
  output logic [COST_W-1:0]         cost_s,
  output logic [COST_W-1:0]         cost_i
);
  import regseq_pkg::*;

  localparam int LIDX_W = $clog2(LIST_W);

  seq_state_t          state;
  logic [LIST_W-1:0]   pend_q;
  logic                extra_q;
  logic                load_q;
  logic                push_q;
  logic                bmode_q;
  logic [REG_AW-1:0]   widx_q;
  logic [DATA_W-1:0]   base_q;
  logic [DATA_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wb_q;

  logic [LIST_W-1:0]   low_onehot;
  logic [LIDX_W-1:0]   low_idx;
  logic                low_any;
  logic                low_more;

  logic                plan_empty;
  logic [DATA_W-1:0]   plan_start;
  logic [DATA_W-1:0]   plan_wb;
  logic [COST_W-1:0]   plan_n;
  logic [COST_W-1:0]   plan_s;
  logic [COST_W-1:0]   plan_i;

  logic [REG_AW-1:0]   cur_idx;
  logic                cur_last;
  logic                in_xfer;

  regseq_pick #(.W(LIST_W)) u_pick (
    .mask   (pend_q),
    .onehot (low_onehot),
    .idx    (low_idx),
    .any    (low_any),
    .more   (low_more)
  );

  regseq_plan #(.LIST_W(LIST_W), .DATA_W(DATA_W), .COST_W(COST_W)) u_plan (
    .list       (pend_q),
    .extra      (extra_q),
    .is_load    (load_q),
    .is_push    (push_q),
    .base       (rf_rdata),
    .empty      (plan_empty),
    .start_addr (plan_start),
    .wb_value   (plan_wb),
    .cost_n     (plan_n),
    .cost_s     (plan_s),
    .cost_i     (plan_i)
  );

  // Current slot: lowest pending listed register, else the extra slot.
  assign in_xfer  = (state == ST_XFER);
  assign cur_idx  = low_any ? REG_AW'(low_idx)
                            : (load_q ? REG_AW'(PC_IDX) : REG_AW'(LR_IDX));
  assign cur_last = low_any ? (!low_more && !extra_q) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pend_q  <= '0;
      extra_q <= 1'b0;
      load_q  <= 1'b0;
      push_q  <= 1'b0;
      bmode_q <= 1'b0;
      widx_q  <= '0;
      base_q  <= '0;
      addr_q  <= '0;
      wb_q    <= '0;
      cost_n  <= '0;
      cost_s  <= '0;
      cost_i  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            pend_q  <= cmd_list;
            extra_q <= cmd_extra && (cmd_mode == MODE_STACK);
            load_q  <= cmd_load;
            push_q  <= (cmd_mode == MODE_STACK) && !cmd_load;
            bmode_q <= (cmd_mode == MODE_BASE);
            widx_q  <= (cmd_mode == MODE_BASE) ? REG_AW'(cmd_base) : REG_AW'(SP_IDX);
            state   <= ST_BASE;
          end
        end
        ST_BASE: begin
          base_q <= rf_rdata;
          addr_q <= plan_start;
          wb_q   <= plan_wb;
          cost_n <= plan_n;
          cost_s <= plan_s;
          cost_i <= plan_i;
          state  <= plan_empty ? ST_IDLE : ST_XFER;
        end
        ST_XFER: begin
          addr_q <= addr_q + DATA_W'(4);
          if (low_any) pend_q <= pend_q & ~low_onehot;
          else         extra_q <= 1'b0;
          if (cur_last) state <= ST_WB;
        end
        ST_WB: begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign done      = (state == ST_WB) || ((state == ST_BASE) && plan_empty);

  assign rf_raddr  = (state == ST_BASE) ? widx_q : (in_xfer ? cur_idx : '0);

  assign mem_en    = in_xfer;
  assign mem_we    = in_xfer && !load_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = (bmode_q && low_any && (REG_AW'(low_idx) == widx_q)) ? base_q : rf_rdata;

  assign rf_we     = (in_xfer && load_q) || (state == ST_WB);
  assign rf_waddr  = (state == ST_WB) ? widx_q : cur_idx;
  assign rf_wdata  = (state == ST_WB) ? wb_q
                   : (low_any ? mem_rdata : (mem_rdata + DATA_W'(4)));
endmodule

// File: rtl/regseq_chk.sv
module regseq_chk #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 4,
  parameter int PC_IDX = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rf_we,
  input logic [REG_AW-1:0] rf_waddr,
  input logic [DATA_W-1:0] rf_wdata,
  input logic              mem_en,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              done
);
  assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> (mem_addr == $past(mem_addr) + DATA_W'(4)));

  assert_pc_refill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we && rf_we && rf_waddr == REG_AW'(PC_IDX))
      |-> (rf_wdata == mem_rdata + DATA_W'(4)));

  assert_store_no_rfwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> !rf_we);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!mem_en && !rf_we && !done));

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
endmodule

bind regseq_top regseq_chk #(
  .DATA_W(DATA_W),
  .REG_AW(REG_AW),
  .PC_IDX(PC_IDX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .rf_we     (rf_we),
  .rf_waddr  (rf_waddr),
  .rf_wdata  (rf_wdata),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_rdata (mem_rdata),
  .done      (done)
);

// File: tb/tb_regseq_top.sv
`timescale 1ns/1ps
module tb_regseq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_mode = 1'b0;
  logic        cmd_load = 1'b0;
  logic [7:0]  cmd_list = '0;
  logic        cmd_extra = 1'b0;
  logic [2:0]  cmd_base = '0;
  logic [3:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic        rf_we;
  logic [3:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        done;
  logic [4:0]  cost_n, cost_s, cost_i;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] rf  [16];
  logic [31:0] mem [256];
  logic        pre_rf_we = 1'b0, pre_mem_we = 1'b0;
  logic [3:0]  pre_ridx = '0;
  logic [31:0] pre_rval = '0, pre_maddr = '0, pre_mval = '0;

  always #2.5 clk = ~clk;

  regseq_top dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .cmd_load(cmd_load), .cmd_list(cmd_list),
    .cmd_extra(cmd_extra), .cmd_base(cmd_base), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .cost_n(cost_n), .cost_s(cost_s),
    .cost_i(cost_i)
  );

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    else if (pre_rf_we) rf[pre_ridx] <= pre_rval;
    if (mem_en && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    else if (pre_mem_we) mem[pre_maddr[9:2]] <= pre_mval;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_reg(input int idx, input logic [31:0] v);
    @(negedge clk); pre_rf_we = 1'b1; pre_ridx = 4'(idx); pre_rval = v;
    @(negedge clk); pre_rf_we = 1'b0;
  endtask

  task automatic set_mem(input logic [31:0] a, input logic [31:0] v);
    @(negedge clk); pre_mem_we = 1'b1; pre_maddr = a; pre_mval = v;
    @(negedge clk); pre_mem_we = 1'b0;
  endtask

  // Issue one command, follow it to done, check handshake and timing.
  task automatic run_op(input logic m, input logic ld, input logic [7:0] lst,
                        input logic ex, input logic [2:0] b,
                        input int exp_lat, input int exp_nx);
    int lat = 0;
    int nx = 0;
    bit rdy_busy = 0;
    @(negedge clk);
    chk("R9 ready while idle", 32'(cmd_ready), 32'd1);
    cmd_valid = 1'b1; cmd_mode = m; cmd_load = ld; cmd_list = lst;
    cmd_extra = ex; cmd_base = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      lat = k;
      if (mem_en) nx++;
      if (cmd_ready) rdy_busy = 1;
      if (done) break;
      @(negedge clk);
    end
    chk("R8 done latency", 32'(lat), 32'(exp_lat));
    chk("R8 transfer count", 32'(nx), 32'(exp_nx));
    chk("R9 ready low while busy", 32'(rdy_busy), 32'd0);
    @(negedge clk);
    chk("R8 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic chk_cost(input string tag, input int n, input int s, input int i);
    chk({tag, " N"}, 32'(cost_n), 32'(n));
    chk({tag, " S"}, 32'(cost_s), 32'(s));
    chk({tag, " I"}, 32'(cost_i), 32'(i));
  endtask

  task automatic t_reset();
    chk("R10 ready in reset", 32'(cmd_ready), 32'd1);
    chk("R10 no strobes in reset", 32'({mem_en, rf_we, done}), 32'd0);
  endtask

  task automatic t_push(input bit with_lr);
    set_reg(0, 32'h0003_9E6C); set_reg(1, 32'h2884_1B97); set_reg(4, 32'h35FE_8EDA);
    set_reg(6, 32'h07D3_B1B5); set_reg(7, 32'h0000_0083); set_reg(14, 32'h000F_3F88);
    set_reg(13, with_lr ? 32'h118 : 32'h114);
    run_op(1'b0, 1'b0, 8'hD3, with_lr, 3'd0, with_lr ? 8 : 7, with_lr ? 6 : 5);
    chk("R1 push r0 lowest", mem[8'h40], 32'h0003_9E6C);
    chk("R1 push r1", mem[8'h41], 32'h2884_1B97);
    chk("R1 push r4", mem[8'h42], 32'h35FE_8EDA);
    chk("R1 push r6", mem[8'h43], 32'h07D3_B1B5);
    chk("R1 push r7", mem[8'h44], 32'h0000_0083);
    if (with_lr) chk("R2 LR on top", mem[8'h45], 32'h000F_3F88);
    chk("R2 SP lowered", rf[13], 32'h100);
    chk_cost(with_lr ? "R6 push+LR" : "R6 push", 2, with_lr ? 5 : 4, 0);
  endtask

  task automatic t_pop(input bit with_pc);
    for (int i = 0; i < 8; i++) set_reg(i, 32'hDEAD_0000 + 32'(i));
    set_reg(15, 32'h0000_0AA0);
    set_mem(32'h200, 32'h1111_0001); set_mem(32'h204, 32'h2222_0002);
    set_mem(32'h208, 32'h3333_0003); set_mem(32'h20C, 32'h4444_0004);
    set_mem(32'h210, 32'h5555_0005); set_mem(32'h214, 32'h0590_2198);
    set_reg(13, 32'h200);
    run_op(1'b0, 1'b1, 8'hD3, with_pc, 3'd0, with_pc ? 8 : 7, with_pc ? 6 : 5);
    chk("R1 pop r0", rf[0], 32'h1111_0001);
    chk("R1 pop r1", rf[1], 32'h2222_0002);
    chk("R1 pop r4", rf[4], 32'h3333_0003);
    chk("R1 pop r6", rf[6], 32'h4444_0004);
    chk("R1 pop r7", rf[7], 32'h5555_0005);
    chk("R5 r2 untouched", rf[2], 32'hDEAD_0002);
    chk("R5 r3 untouched", rf[3], 32'hDEAD_0003);
    chk("R5 r5 untouched", rf[5], 32'hDEAD_0005);
    chk("R3 SP raised", rf[13], with_pc ? 32'h218 : 32'h214);
    chk("R3 PC refill", rf[15], with_pc ? 32'h0590_219C : 32'h0000_0AA0);
    chk_cost(with_pc ? "R6 pop+PC" : "R6 pop", with_pc ? 2 : 1, with_pc ? 7 : 5, 1);
  endtask

  task automatic t_base_store();
    set_reg(0, 32'hA000_0000); set_reg(4, 32'hA000_0004);
    set_reg(6, 32'hA000_0006); set_reg(7, 32'hA000_0007);
    set_reg(2, 32'h300);
    run_op(1'b1, 1'b0, 8'hD5, 1'b0, 3'd2, 7, 5);
    chk("R1 base store r0", mem[8'hC0], 32'hA000_0000);
    chk("R4 base stores original", mem[8'hC1], 32'h300);
    chk("R1 base store r7", mem[8'hC4], 32'hA000_0007);
    chk("R4 base writeback", rf[2], 32'h314);
    chk_cost("R6 base store", 2, 4, 0);
  endtask

  task automatic t_base_load();
    for (int i = 0; i < 8; i++) set_reg(i, 32'hBEEF_0000 + 32'(i));
    set_reg(15, 32'h0000_0C00);
    set_reg(2, 32'h300);
    set_mem(32'h300, 32'h7000_0000); set_mem(32'h304, 32'h7000_0002);
    set_mem(32'h308, 32'h7000_0004); set_mem(32'h30C, 32'h7000_0006);
    set_mem(32'h310, 32'h7000_0007); set_mem(32'h314, 32'h7777_7777);
    run_op(1'b1, 1'b1, 8'hD5, 1'b1, 3'd2, 7, 5);
    chk("R1 base load r0", rf[0], 32'h7000_0000);
    chk("R1 base load r6", rf[6], 32'h7000_0006);
    chk("R4 writeback wins", rf[2], 32'h314);
    chk("R5 r1 untouched", rf[1], 32'hBEEF_0001);
    chk("R4 extra ignored PC", rf[15], 32'h0000_0C00);
    chk_cost("R6 base load", 1, 5, 1);
  endtask

  task automatic t_empty();
    set_reg(13, 32'h180);
    set_mem(32'h17C, 32'h5A5A_5A5A);
    run_op(1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 1, 0);
    chk("R7 SP unchanged", rf[13], 32'h180);
    chk("R7 no memory write", mem[8'h5F], 32'h5A5A_5A5A);
    chk_cost("R7 empty cost", 0, 0, 0);
  endtask

  task automatic t_full_push();
    for (int i = 0; i < 8; i++) set_reg(i, 32'hC0DE_0000 + 32'(i));
    set_reg(14, 32'h0000_4E4E);
    set_reg(13, 32'h024 + 32'h100);
    run_op(1'b0, 1'b0, 8'hFF, 1'b1, 3'd0, 11, 9);
    chk("R1 full push r0", mem[8'h40], 32'hC0DE_0000);
    chk("R1 full push r7", mem[8'h47], 32'hC0DE_0007);
    chk("R2 full push LR", mem[8'h48], 32'h0000_4E4E);
    chk("R2 full push SP", rf[13], 32'h100);
    chk_cost("R6 full push", 2, 8, 0);
  endtask

  // A command held valid while busy must wait and then run.
  task automatic t_backpressure();
    int lat = 0;
    bit rdy_busy = 0;
    set_reg(0, 32'h0123_4567); set_reg(1, 32'h89AB_CDEF);
    set_reg(3, 32'h380); set_reg(4, 32'h390);
    set_mem(32'h384, 32'h0BAD_0BAD);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mode = 1'b1; cmd_load = 1'b0;
    cmd_list = 8'h01; cmd_base = 3'd3; cmd_extra = 1'b0;
    @(negedge clk);
    cmd_list = 8'h02; cmd_base = 3'd4;
    for (int k = 1; k <= 20; k++) begin
      lat = k;
      if (cmd_ready) rdy_busy = 1;
      if (done) break;
      @(negedge clk);
    end
    chk("R9 first latency", 32'(lat), 32'd3);
    chk("R9 ready low while held", 32'(rdy_busy), 32'd0);
    @(negedge clk);
    chk("R9 ready after done", 32'(cmd_ready), 32'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 6; k++) @(negedge clk);
    chk("R9 first store", mem[8'hE0], 32'h0123_4567);
    chk("R9 first writeback", rf[3], 32'h384);
    chk("R9 held list not mixed in", mem[8'hE1], 32'h0BAD_0BAD);
    chk("R9 second store", mem[8'hE4], 32'h89AB_CDEF);
    chk("R9 second writeback", rf[4], 32'h394);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_push(1'b0);
    t_push(1'b1);
    t_pop(1'b0);
    t_pop(1'b1);
    t_base_store();
    t_base_load();
    t_empty();
    t_full_push();
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule